// File: doc/BRIEF.md
# Protected-Mode Interrupt Gate Dispatcher

This block turns an interrupt or exception vector into a complete protected-mode dispatch decision. It fetches the gate from the interrupt descriptor table, walks the chain of gate, privilege and presence checks, and fetches and checks the target code segment. For an inner-privilege target it also fetches and checks the stack named by the task segment. It then streams out the values to be pushed, one per cycle, and reports the new CS, EIP, SS, ESP, CPL and flags. Otherwise it reports one fault vector with its error code. A task gate is not executed here; it is handed to an external task-switch unit as a request carrying the gate's selector.

All lookups go through one read port with a fixed latency of one cycle. The requester drives `rd_req`, `rd_kind` and `rd_addr`, and the responder returns `rd_data` (and `rd_ok` for selector lookups) on the following cycle. Kind 0 reads 8 bytes at a linear address. Kind 1 resolves a selector to its descriptor, and `rd_ok` low means the selector cannot be loaded. Kind 2 returns the inner stack for privilege level `rd_addr[1:0]` as `{16'h0, ss, esp}`. The caller pulses `start` and holds all other inputs steady until `done`.

Top module: `gate_dispatch`

## Requirements
- R1: If vector*8+7 is greater than `idt_limit`, the block ends with fault vector 13 and error code vector*8+2, and it makes no read. A vector whose last gate byte equals the limit is accepted.
- R2: The gate type is bits [44:40] of the gate (type 5 = task gate, 6/7 = 16-bit, 14/15 = 32-bit). Any other type faults with vector 13 and error code vector*8+2. A present task gate ends with `task_req` high and `task_sel` equal to gate bits [31:16], with no push and no fault. A task gate whose present bit [47] is clear faults with vector 11 and error code vector*8+2.
- R3: For a software interrupt, a gate DPL (bits [46:45]) below CPL faults with vector 13 and error code vector*8+2. Hardware interrupts and exceptions skip this check. A gate whose present bit is clear faults with vector 11 and error code vector*8+2.
- R4: A target selector (gate bits [31:16]) whose index and table bits are zero faults with vector 13 and error code 0. The target must load (`rd_ok`), and it must have S (bit 44) and code (bit 43) set and a DPL (bits [46:45]) not above CPL; otherwise the fault is vector 13 with error code selector&0xFFFC. A target that is not present (bit 47) faults with vector 11 and the same code.
- R5: At the same privilege (conforming target, bit 42, or target DPL equal to CPL), the block pushes EFLAGS, then CS, then the saved EIP on the current stack. The saved EIP is `next_eip` for software interrupts and `cur_eip` otherwise. Each value is 4 bytes with `push_wide` high when gate type bit 3 is set, and 2 bytes with the value zero-extended from its low 16 bits otherwise.
- R6: An error code is pushed last only for vectors 8, 10, 11, 12, 13, 14 and 17, and only when neither `sw_int` nor `hw_int` is set.
- R7: A non-conforming target with DPL below CPL takes SS:ESP from the kind-2 read and pushes the old SS and old ESP before EFLAGS. If the new SS is null, its RPL differs from the target DPL, it cannot be loaded, its DPL differs, it is not a writable data segment (S bit 44 set, code bit 43 clear, write bit 41 set), or it is not present, the block faults with vector 10 and error code SS&0xFFFC.
- R8: With VM (EFLAGS bit 17) set, an inner-stack dispatch first pushes GS, FS, DS and ES, in that order. A same-privilege target from VM faults with vector 13 and error code selector&0xFFFC.
- R9: On success the new EFLAGS has TF (8), NT (14), RF (16) and VM (17) cleared. IF (9) is also cleared when gate type bit 0 is clear.
- R10: On success the new CS is the target selector with its RPL replaced by the target DPL, and that DPL becomes the new CPL. The new EIP is gate bits {[63:48],[15:0]}. The new ESP is the start ESP less the bytes pushed, and only its low 16 bits change when the stack's B bit (bit 54, or `ss_big` for the current stack) is clear.
- R11: Checks run in the order above and only the first failure is reported. After a fault, no value is pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a dispatch (accepted when idle) |
| sw_int | input | 1 | Event is a software interrupt |
| hw_int | input | 1 | Event is an external interrupt |
| vector | input | 8 | Interrupt or exception vector |
| err_code | input | 16 | Error code for exceptions that carry one |
| cur_eip | input | 32 | EIP of the current instruction |
| next_eip | input | 32 | EIP after the current instruction |
| cpl | input | 2 | Current privilege level |
| eflags | input | 32 | Current flags |
| esp | input | 32 | Current stack pointer |
| ss_big | input | 1 | B bit of the current stack segment |
| cs_sel | input | 16 | Current CS selector |
| ss_sel | input | 16 | Current SS selector |
| ds_sel | input | 16 | Current DS selector |
| es_sel | input | 16 | Current ES selector |
| fs_sel | input | 16 | Current FS selector |
| gs_sel | input | 16 | Current GS selector |
| idt_base | input | 32 | Interrupt table base address |
| idt_limit | input | 16 | Interrupt table limit |
| rd_req | output | 1 | Read request |
| rd_kind | output | 2 | 0 linear, 1 selector, 2 inner stack |
| rd_addr | output | 32 | Address, selector or level |
| rd_data | input | 64 | Read result, one cycle after the request |
| rd_ok | input | 1 | Selector lookup succeeded |
| busy | output | 1 | Dispatch in progress |
| push_valid | output | 1 | A push value is presented this cycle |
| push_wide | output | 1 | Push is 4 bytes (else 2) |
| push_data | output | 32 | Value to push |
| done | output | 1 | One-cycle end-of-dispatch pulse |
| fault | output | 1 | Dispatch ended with a fault |
| fault_vec | output | 8 | Fault vector (10, 11 or 13) |
| fault_err | output | 16 | Fault error code |
| task_req | output | 1 | Task gate handed to the task-switch unit |
| task_sel | output | 16 | Task gate selector |
| new_cs | output | 16 | New CS selector |
| new_eip | output | 32 | New EIP |
| new_ss | output | 16 | New SS selector |
| new_esp | output | 32 | New stack pointer |
| new_cpl | output | 2 | New privilege level |
| new_eflags | output | 32 | New flags |

## Verification
On every cycle the assertions check a set of invariants. At most one of a read, a push and a completion is active in any cycle. A narrow push carries no upper bits. A fault is never preceded by a push. A successful dispatch never raises privilege number above CPL, and it always leaves TF, NT, RF and VM clear. Only the directed scenarios can show the rest. That covers the order in which the checks fire, and the exact error codes for the gate, target and stack faults. It also covers the layout of the push stream for the same-privilege, inner, VM and error-code cases, and the 16-bit stack wrap.

// File: rtl/gate_dispatch.sv
module gate_dispatch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        sw_int,
  input  logic        hw_int,
  input  logic [7:0]  vector,
  input  logic [15:0] err_code,
  input  logic [31:0] cur_eip,
  input  logic [31:0] next_eip,
  input  logic [1:0]  cpl,
  input  logic [31:0] eflags,
  input  logic [31:0] esp,
  input  logic        ss_big,
  input  logic [15:0] cs_sel,
  input  logic [15:0] ss_sel,
  input  logic [15:0] ds_sel,
  input  logic [15:0] es_sel,
  input  logic [15:0] fs_sel,
  input  logic [15:0] gs_sel,
  input  logic [31:0] idt_base,
  input  logic [15:0] idt_limit,
  output logic        rd_req,
  output logic [1:0]  rd_kind,
  output logic [31:0] rd_addr,
  input  logic [63:0] rd_data,
  input  logic        rd_ok,
  output logic        busy,
  output logic        push_valid,
  output logic        push_wide,
  output logic [31:0] push_data,
  output logic        done,
  output logic        fault,
  output logic [7:0]  fault_vec,
  output logic [15:0] fault_err,
  output logic        task_req,
  output logic [15:0] task_sel,
  output logic [15:0] new_cs,
  output logic [31:0] new_eip,
  output logic [15:0] new_ss,
  output logic [31:0] new_esp,
  output logic [1:0]  new_cpl,
  output logic [31:0] new_eflags
);
  typedef enum logic [3:0] {S_IDLE, S_GREQ, S_GCHK, S_CREQ, S_CCHK,
                            S_TREQ, S_TCHK, S_SREQ, S_SCHK, S_PUSH} st_t;
  st_t state;

  logic [4:0]  gtype;
  logic [31:0] goff, run_esp;
  logic [15:0] gsel, nss;
  logic [1:0]  tdpl;
  logic        inner, sbig;
  logic [3:0]  pcnt, npush;
  logic [31:0] plist [0:9];

  logic        f;
  logic [7:0]  fv;
  logic [15:0] fe;

  wire        vm       = eflags[17];
  wire [15:0] vec_err  = {5'd0, vector, 3'b010};
  wire        lim_bad  = {5'd0, vector, 3'b111} > idt_limit;
  wire [15:0] sel_err  = {gsel[15:2], 2'b00};
  wire [15:0] nss_err  = {nss[15:2], 2'b00};
  wire [1:0]  d_dpl    = rd_data[46:45];
  wire        to_inner = !rd_data[42] && (d_dpl < cpl);
  wire        has_err  = !sw_int && !hw_int &&
                         (vector == 8'd8  || vector == 8'd10 || vector == 8'd11 ||
                          vector == 8'd12 || vector == 8'd13 || vector == 8'd14 ||
                          vector == 8'd17);
  wire [31:0] saved_eip = sw_int ? next_eip : cur_eip;
  wire [15:0] dec16     = gtype[3] ? 16'd4 : 16'd2;
  wire [31:0] dec_esp   = run_esp - {16'd0, dec16};
  wire [31:0] esp_dec   = sbig ? dec_esp : {run_esp[31:16], dec_esp[15:0]};
  wire        gate_ok   = (rd_data[44:40] == 5'd6)  || (rd_data[44:40] == 5'd7) ||
                          (rd_data[44:40] == 5'd14) || (rd_data[44:40] == 5'd15);

  assign busy       = state != S_IDLE;
  assign rd_req     = (state == S_GREQ) || (state == S_CREQ) ||
                      (state == S_TREQ) || (state == S_SREQ);
  assign rd_kind    = (state == S_TREQ) ? 2'd2 : (state == S_GREQ) ? 2'd0 : 2'd1;
  assign rd_addr    = (state == S_GREQ) ? idt_base + {21'd0, vector, 3'b000} :
                      (state == S_TREQ) ? {30'd0, tdpl} :
                      (state == S_SREQ) ? {16'd0, nss} : {16'd0, gsel};
  assign push_valid = state == S_PUSH;
  assign push_wide  = gtype[3];
  assign push_data  = gtype[3] ? plist[pcnt] : {16'd0, plist[pcnt][15:0]};

  always_comb begin
    int k;
    for (int i = 0; i < 10; i++) plist[i] = '0;
    k = 0;
    if (inner && vm) begin
      plist[0] = {16'd0, gs_sel}; plist[1] = {16'd0, fs_sel};
      plist[2] = {16'd0, ds_sel}; plist[3] = {16'd0, es_sel};
      k = 4;
    end
    if (inner) begin
      plist[k] = {16'd0, ss_sel}; plist[k+1] = esp;
      k = k + 2;
    end
    plist[k] = eflags; plist[k+1] = {16'd0, cs_sel}; plist[k+2] = saved_eip;
    k = k + 3;
    if (has_err) begin
      plist[k] = {16'd0, err_code};
      k = k + 1;
    end
    npush = 4'(k);
  end

  always_comb begin
    f = 1'b0; fv = 8'd13; fe = 16'd0;
    case (state)
      S_IDLE: if (start && lim_bad) begin f = 1'b1; fe = vec_err; end
      S_GCHK: begin
        fe = vec_err;
        if (rd_data[44:40] == 5'd5) begin
          if (!rd_data[47]) begin f = 1'b1; fv = 8'd11; end
        end else if (!gate_ok) f = 1'b1;
        else if (sw_int && d_dpl < cpl) f = 1'b1;
        else if (!rd_data[47]) begin f = 1'b1; fv = 8'd11; end
        else if (rd_data[31:18] == 14'd0) begin f = 1'b1; fe = 16'd0; end
      end
      S_CCHK: begin
        fe = sel_err;
        if (!rd_ok || !rd_data[44] || !rd_data[43] || d_dpl > cpl) f = 1'b1;
        else if (!rd_data[47]) begin f = 1'b1; fv = 8'd11; end
        else if (!to_inner && vm) f = 1'b1;
      end
      S_TCHK: begin
        fv = 8'd10; fe = {rd_data[47:34], 2'b00};
        if (rd_data[47:34] == 14'd0 || rd_data[33:32] != tdpl) f = 1'b1;
      end
      S_SCHK: begin
        fv = 8'd10; fe = nss_err;
        if (!rd_ok || d_dpl != tdpl || !rd_data[44] || rd_data[43] ||
            !rd_data[41] || !rd_data[47]) f = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; gtype <= '0; goff <= '0; gsel <= '0; nss <= '0;
      tdpl <= '0; inner <= 1'b0; sbig <= 1'b0; run_esp <= '0; pcnt <= '0;
      done <= 1'b0; fault <= 1'b0; fault_vec <= '0; fault_err <= '0;
      task_req <= 1'b0; task_sel <= '0; new_cs <= '0; new_eip <= '0;
      new_ss <= '0; new_esp <= '0; new_cpl <= '0; new_eflags <= '0;
    end else begin
      done <= 1'b0; fault <= 1'b0; task_req <= 1'b0;
      if (f) begin
        done <= 1'b1; fault <= 1'b1; fault_vec <= fv; fault_err <= fe;
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (start) state <= S_GREQ;
          S_GREQ: state <= S_GCHK;
          S_GCHK:
            if (rd_data[44:40] == 5'd5) begin
              task_req <= 1'b1; task_sel <= rd_data[31:16]; done <= 1'b1;
              state <= S_IDLE;
            end else begin
              gtype <= rd_data[44:40];
              goff  <= {rd_data[63:48], rd_data[15:0]};
              gsel  <= rd_data[31:16];
              state <= S_CREQ;
            end
          S_CREQ: state <= S_CCHK;
          S_CCHK:
            if (to_inner) begin
              tdpl <= d_dpl; state <= S_TREQ;
            end else begin
              tdpl <= cpl; run_esp <= esp; sbig <= ss_big; inner <= 1'b0;
              pcnt <= '0; state <= S_PUSH;
            end
          S_TREQ: state <= S_TCHK;
          S_TCHK: begin
            nss <= rd_data[47:32]; run_esp <= rd_data[31:0]; state <= S_SREQ;
          end
          S_SREQ: state <= S_SCHK;
          S_SCHK: begin
            sbig <= rd_data[54]; inner <= 1'b1; pcnt <= '0; state <= S_PUSH;
          end
          S_PUSH: begin
            run_esp <= esp_dec;
            pcnt    <= pcnt + 4'd1;
            if (pcnt == npush - 4'd1) begin
              done       <= 1'b1;
              new_esp    <= esp_dec;
              new_cs     <= {gsel[15:2], tdpl};
              new_cpl    <= tdpl;
              new_eip    <= goff;
              new_ss     <= inner ? {nss[15:2], tdpl} : ss_sel;
              new_eflags <= eflags & ~32'h0003_4100 & ~(gtype[0] ? 32'h0 : 32'h0000_0200);
              state      <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_one_activity_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_req, push_valid, done}));
  assert_no_push_before_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !$past(push_valid));
  assert_narrow_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_wide |-> push_data[31:16] == 16'd0);
  assert_target_not_outer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && !task_req |-> new_cpl <= cpl);
  assert_flags_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && !task_req |-> (new_eflags & 32'h0003_4100) == 32'h0);
  assert_read_while_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);
endmodule

// File: tb/gate_dispatch_tb.sv
module gate_dispatch_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sw_int, hw_int, ss_big;
  logic [7:0] vector;
  logic [15:0] err_code, cs_sel, ss_sel, ds_sel, es_sel, fs_sel, gs_sel, idt_limit;
  logic [31:0] cur_eip, next_eip, eflags, esp, idt_base;
  logic [1:0] cpl;
  logic rd_req, rd_ok, busy, push_valid, push_wide, done, fault, task_req;
  logic [1:0] rd_kind, new_cpl;
  logic [31:0] rd_addr, push_data, new_eip, new_esp, new_eflags;
  logic [63:0] rd_data;
  logic [7:0] fault_vec;
  logic [15:0] fault_err, task_sel, new_cs, new_ss;

  logic [63:0] g_desc, c_desc, s_desc;
  logic c_ok, s_ok;
  logic [15:0] t_ss;
  logic [31:0] t_esp;
  logic [31:0] pv [0:15];
  logic pw;
  int pn, n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gate_dispatch u_dut (.*);

  always @(posedge clk) if (rd_req) begin
    case (rd_kind)
      2'd0: begin rd_data <= g_desc; rd_ok <= 1'b1; end
      2'd1: if (rd_addr[15:0] == t_ss) begin rd_data <= s_desc; rd_ok <= s_ok; end
            else begin rd_data <= c_desc; rd_ok <= c_ok; end
      default: begin rd_data <= {16'd0, t_ss, t_esp}; rd_ok <= 1'b1; end
    endcase
  end

  function automatic logic [63:0] gd(logic [15:0] sel, logic [31:0] off, logic [4:0] ty,
                                     logic [1:0] dpl, logic p);
    return {off[31:16], p, dpl, ty, 8'h00, sel, off[15:0]};
  endfunction
  function automatic logic [63:0] sd(logic big, logic p, logic [1:0] dpl, logic s,
                                     logic code, logic conf, logic w);
    return {8'h00, 1'b0, big, 6'h0, p, dpl, s, code, conf, w, 1'b0, 40'h0};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic defaults();
    sw_int = 0; hw_int = 0; vector = 8'd32; err_code = 16'h5A5A;
    cur_eip = 32'h1111_0000; next_eip = 32'h1111_0004; cpl = 2'd0;
    eflags = 32'h2; esp = 32'h1000; ss_big = 1;
    cs_sel = 16'h0008; ss_sel = 16'h0010; ds_sel = 16'h0018; es_sel = 16'h0020;
    fs_sel = 16'h0028; gs_sel = 16'h0030; idt_base = 32'h8000; idt_limit = 16'h07FF;
    g_desc = gd(16'h0048, 32'h0012_3456, 5'd14, 2'd0, 1'b1);
    c_desc = sd(1, 1, 2'd0, 1, 1, 0, 1); c_ok = 1;
    s_desc = sd(1, 1, 2'd0, 1, 0, 0, 1); s_ok = 1;
    t_ss = 16'h0050; t_esp = 32'h2000;
  endtask

  task automatic run();
    pn = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int i = 0; i < 60; i++) begin
      if (push_valid) begin pv[pn] = push_data; pw = push_wide; pn++; end
      if (done) break;
      @(negedge clk);
    end
    chk("done", {31'd0, done}, 32'd1);
  endtask

  task automatic expect_fault(string req, logic [7:0] v, logic [15:0] e);
    run();
    chk(req, {31'd0, fault}, 32'd1);
    chk(req, {24'd0, fault_vec}, {24'd0, v});
    chk(req, {16'd0, fault_err}, {16'd0, e});
    chk(req, pn, 0);
  endtask

  task automatic t_reset();
    chk("reset R11", {29'd0, busy, push_valid, done}, 32'd0);
  endtask

  task automatic t_same_priv_R5();
    defaults(); hw_int = 1; eflags = 32'h0001_4302;
    run();
    chk("R5 fault", {31'd0, fault}, 0); chk("R5 count", pn, 3);
    chk("R5 wide", {31'd0, pw}, 1);
    chk("R5 eflags", pv[0], 32'h0001_4302); chk("R5 cs", pv[1], 32'h8);
    chk("R5 eip", pv[2], 32'h1111_0000);
    chk("R10 esp", new_esp, 32'h0FF4); chk("R10 eip", new_eip, 32'h0012_3456);
    chk("R10 cs", {16'd0, new_cs}, 32'h48); chk("R10 ss", {16'd0, new_ss}, 32'h10);
    chk("R9 int gate", new_eflags, 32'h2);
  endtask

  task automatic t_error_code_R6();
    defaults(); vector = 8'd14; eflags = 32'h4202;
    g_desc = gd(16'h0048, 32'h0000_9000, 5'd15, 2'd0, 1'b1);
    run();
    chk("R6 count", pn, 4); chk("R6 err", pv[3], 32'h5A5A);
    chk("R6 eip", pv[2], 32'h1111_0000); chk("R6 esp", new_esp, 32'h0FF0);
    chk("R9 trap gate", new_eflags, 32'h202);
  endtask

  task automatic t_inner_R7();
    defaults(); sw_int = 1; vector = 8'd13; cpl = 2'd3; cs_sel = 16'h001B;
    ss_sel = 16'h0023; esp = 32'h7000;
    g_desc = gd(16'h0048, 32'h0000_4000, 5'd14, 2'd3, 1'b1);
    run();
    chk("R7 fault", {31'd0, fault}, 0); chk("R6 sw no err", pn, 5);
    chk("R7 oldss", pv[0], 32'h23); chk("R7 oldesp", pv[1], 32'h7000);
    chk("R7 eflags", pv[2], 32'h2); chk("R7 cs", pv[3], 32'h1B);
    chk("R5 next eip", pv[4], 32'h1111_0004);
    chk("R7 newss", {16'd0, new_ss}, 32'h50); chk("R7 newesp", new_esp, 32'h1FEC);
    chk("R10 cpl", {30'd0, new_cpl}, 0); chk("R10 rpl", {16'd0, new_cs}, 32'h48);
  endtask

  task automatic t_narrow_R10();
    defaults(); hw_int = 1; vector = 8'd40; ss_big = 0; esp = 32'hABCD_0002;
    eflags = 32'h202; cur_eip = 32'h1111_2222;
    g_desc = gd(16'h0048, 32'h0000_0100, 5'd6, 2'd0, 1'b1);
    run();
    chk("R5 narrow", {31'd0, pw}, 0); chk("R5 count", pn, 3);
    chk("R5 eflags16", pv[0], 32'h202); chk("R5 eip16", pv[2], 32'h2222);
    chk("R10 wrap", new_esp, 32'hABCD_FFFC); chk("R9 16bit int", new_eflags, 32'h2);
  endtask

  task automatic t_vm_R8();
    defaults(); hw_int = 1; vector = 8'd33; cpl = 2'd3; eflags = 32'h0002_0202;
    run();
    chk("R8 count", pn, 9);
    chk("R8 gs", pv[0], 32'h30); chk("R8 fs", pv[1], 32'h28);
    chk("R8 ds", pv[2], 32'h18); chk("R8 es", pv[3], 32'h20);
    chk("R8 ss", pv[4], 32'h10); chk("R8 esp", pv[5], 32'h1000);
    chk("R8 eflags", pv[6], 32'h0002_0202); chk("R8 newesp", new_esp, 32'h1FDC);
    chk("R9 vm clear", new_eflags, 32'h2);
    defaults(); hw_int = 1; cpl = 2'd3; eflags = 32'h0002_0202;
    c_desc = sd(1, 1, 2'd0, 1, 1, 1, 1);
    expect_fault("R8 vm same priv", 8'd13, 16'h48);
  endtask

  task automatic t_limit_R1();
    defaults(); idt_limit = 16'h00FF;
    expect_fault("R1 limit", 8'd13, 16'h0102);
    defaults(); idt_limit = 16'h00FF; vector = 8'd31; hw_int = 1;
    run(); chk("R1 edge ok", {31'd0, fault}, 0);
  endtask

  task automatic t_gate_type_R2();
    defaults(); g_desc = gd(16'h0048, 32'h0, 5'd12, 2'd0, 1'b1);
    expect_fault("R2 bad type", 8'd13, 16'h0102);
    defaults(); g_desc = gd(16'h0060, 32'h0, 5'd5, 2'd0, 1'b1);
    run();
    chk("R2 task req", {31'd0, task_req}, 1); chk("R2 task sel", {16'd0, task_sel}, 32'h60);
    chk("R2 task nofault", {31'd0, fault}, 0); chk("R2 task nopush", pn, 0);
    defaults(); g_desc = gd(16'h0060, 32'h0, 5'd5, 2'd0, 1'b0);
    expect_fault("R2 task np", 8'd11, 16'h0102);
  endtask

  task automatic t_gate_priv_R3();
    defaults(); sw_int = 1; vector = 8'h80; cpl = 2'd3;
    expect_fault("R3 sw dpl", 8'd13, 16'h0402);
    defaults(); sw_int = 1; vector = 8'h80; cpl = 2'd3;
    g_desc = gd(16'h0048, 32'h0, 5'd14, 2'd0, 1'b0);
    expect_fault("R11 first failure", 8'd13, 16'h0402);
    defaults(); g_desc = gd(16'h0048, 32'h0, 5'd14, 2'd0, 1'b0);
    expect_fault("R3 gate np", 8'd11, 16'h0102);
  endtask

  task automatic t_target_R4();
    defaults(); g_desc = gd(16'h0003, 32'h0, 5'd14, 2'd0, 1'b1);
    expect_fault("R4 null sel", 8'd13, 16'h0);
    defaults(); g_desc = gd(16'h004B, 32'h0, 5'd14, 2'd0, 1'b1);
    c_desc = sd(1, 1, 2'd0, 1, 0, 0, 1);
    expect_fault("R4 not code", 8'd13, 16'h48);
    defaults(); c_desc = sd(1, 1, 2'd2, 1, 1, 0, 1);
    expect_fault("R4 dpl above", 8'd13, 16'h48);
    defaults(); c_desc = sd(1, 0, 2'd0, 1, 1, 0, 1);
    expect_fault("R4 np", 8'd11, 16'h48);
    defaults(); c_ok = 0;
    expect_fault("R4 load fail", 8'd13, 16'h48);
  endtask

  task automatic t_stack_R7();
    defaults(); cpl = 2'd3; t_ss = 16'h0;
    expect_fault("R7 null ss", 8'd10, 16'h0);
    defaults(); cpl = 2'd3; t_ss = 16'h0053;
    expect_fault("R7 rpl", 8'd10, 16'h50);
    defaults(); cpl = 2'd3; s_desc = sd(1, 1, 2'd0, 1, 0, 0, 0);
    expect_fault("R7 not writable", 8'd10, 16'h50);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    defaults();
    rd_data = '0; rd_ok = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_same_priv_R5();
    t_error_code_R6();
    t_inner_R7();
    t_narrow_R10();
    t_vm_R8();
    t_limit_R1();
    t_gate_type_R2();
    t_gate_priv_R3();
    t_target_R4();
    t_stack_R7();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule